// File: doc/BRIEF.md
# Exhaustive Bitwise Fitness Scorer

This block grades a small combinational circuit under test by driving it through every input combination of a chosen reference function and counting, bit by bit, how many of its outputs agree with a golden model held inside the block. A wrong vector therefore still earns credit for each output bit that happens to be right. The result is a graded score rather than a single pass/fail verdict. That score is what a search procedure needs to rank candidate circuits against one another.

Three reference functions are available: a product of two 3-bit operands, a sum of two 3-bit operands, and a hexadecimal seven-segment pattern for a 4-bit value. Each function has its own top score. The user picks a function, sets a settle count, and pulses start. The block then walks the vectors in ascending order. It holds each vector steady long enough for the circuit under test to settle, and it adds the matching bits to a 9-bit score. At the end it raises a one-cycle done pulse, and it raises a perfect flag when every checked bit agreed.

The controller moves through four states. ST_IDLE goes to ST_SETTLE when start is accepted. ST_SETTLE goes to ST_SAMPLE when the wait count reaches zero. ST_SAMPLE goes back to ST_SETTLE when more vectors remain, and to ST_FINISH after the last vector. ST_FINISH always returns to ST_IDLE.

Top module: `fitness_scorer`

## Requirements
- R1: After reset, fitness, done and perfect are 0, cut_in is 0 and the block is idle.
- R2: A start is accepted only while the block is idle. Accepting it latches func_sel and settle_cycles, clears fitness to 0 on that same edge, and begins the sweep at vector 0. A start that arrives while a sweep or its finish cycle is under way has no effect on the score, the function or the timing.
- R3: With func_sel 00 (product), operand A is on cut_in[2:0] and operand B on cut_in[5:3]. The 64 vectors run 0 to 63 as the value of {B,A}. cut_out[5:0] is checked against A*B, for a top score of 384.
- R4: With func_sel 01 (sum), the operands and the 64 vectors are laid out as in R3. cut_out[3:0] is checked against A+B, for a top score of 256.
- R5: With func_sel 10 or 11 (hex segments), cut_in[3:0] carries the values 0 to 15 and cut_in[5:4] is 0. cut_out[6:0] is checked against active-high segments a..g on bits 0..6, for all sixteen digits including A to F, for a top score of 112.
- R6: Every checked output bit adds one point on its own, independent of the other bits of the same vector. Output bits that the selected function does not check never affect the score.
- R7: Each vector is held on cut_in for settle_cycles+2 clock cycles, and the output is compared in the last of them. done is therefore high N*(settle_cycles+2) cycles after the edge that accepted start, where N is the number of vectors.
- R8: done is high for exactly one cycle, in the cycle that follows the last comparison. fitness keeps its final value until the next accepted start.
- R9: perfect is high from the done cycle until the next accepted start if, and only if, fitness equals the top score of the latched function. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a sweep |
| func_sel | input | 2 | Reference function: 00 product, 01 sum, 10/11 hex segments |
| settle_cycles | input | 4 | Extra settle cycles per vector |
| cut_out | input | 7 | Output bus of the circuit under test |
| cut_in | output | 6 | Drive vector to the circuit under test |
| fitness | output | 9 | Count of matching output bits |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| perfect | output | 1 | Every checked bit matched |

## Verification
The bench feeds the block a model circuit with injected faults: stuck-low, stuck-high, single-bit inversion and full inversion. The expected scores are worked out by hand from the arithmetic, so partial credit per bit is tested. A design that scored per vector would report 0 or far too little for the sum with an inverted carry (192) or the product with a stuck top bit (326). Flipping the unchecked bit 6 in product mode, and inverting all outputs in sum mode, catches a mask that leaks, which would give a score other than 384 and 0. The cycle count from start to done at several settle values, a start issued in the middle of a sweep, and the segment table entries for A to F catch a wrong settle window, a restart while busy, and a table that stops at nine.

// File: rtl/fit_pkg.sv
package fit_pkg;

    localparam int OPW      = 3;
    localparam int VEC_W    = 2 * OPW;
    localparam int HEX_W    = 4;
    localparam int SEG_N    = 7;
    localparam int OUT_W    = SEG_N;
    localparam int SCORE_W  = 9;
    localparam int SETTLE_W = 4;

    typedef enum logic [1:0] {
        MODE_MUL = 2'd0,
        MODE_ADD = 2'd1,
        MODE_HEX = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_FINISH
    } state_e;

    function automatic mode_e decode_sel(input logic [1:0] sel);
        mode_e m;
        unique case (sel)
            2'd0:    m = MODE_MUL;
            2'd1:    m = MODE_ADD;
            default: m = MODE_HEX;
        endcase
        return m;
    endfunction

    function automatic logic [VEC_W-1:0] last_vec(input mode_e m);
        logic [VEC_W-1:0] v;
        if (m == MODE_HEX) v = VEC_W'((1 << HEX_W) - 1);
        else               v = '1;
        return v;
    endfunction

    function automatic logic [SCORE_W-1:0] max_score(input mode_e m);
        logic [SCORE_W-1:0] s;
        unique case (m)
            MODE_MUL: s = SCORE_W'((1 << VEC_W) * (2 * OPW));
            MODE_ADD: s = SCORE_W'((1 << VEC_W) * (OPW + 1));
            default:  s = SCORE_W'((1 << HEX_W) * SEG_N);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fit_golden.sv
module fit_golden
    import fit_pkg::*;
#(
    parameter int OW = OUT_W,
    parameter int VW = VEC_W,
    parameter int AW = OPW
) (
    input  mode_e          mode,
    input  logic [VW-1:0]  vec,
    output logic [VW-1:0]  drive,
    output logic [OW-1:0]  gold,
    output logic [OW-1:0]  mask
);

    localparam int PW = 2 * AW;
    localparam int SW = AW + 1;

    logic [AW-1:0] op_a;
    logic [AW-1:0] op_b;
    logic [PW-1:0] prod;
    logic [SW-1:0] sum;

    function automatic logic [SEG_N-1:0] seg_pattern(input logic [HEX_W-1:0] d);
        logic [SEG_N-1:0] p;
        unique case (d)
            4'h0: p = 7'h3F;
            4'h1: p = 7'h06;
            4'h2: p = 7'h5B;
            4'h3: p = 7'h4F;
            4'h4: p = 7'h66;
            4'h5: p = 7'h6D;
            4'h6: p = 7'h7D;
            4'h7: p = 7'h07;
            4'h8: p = 7'h7F;
            4'h9: p = 7'h6F;
            4'hA: p = 7'h77;
            4'hB: p = 7'h7C;
            4'hC: p = 7'h39;
            4'hD: p = 7'h5E;
            4'hE: p = 7'h79;
            default: p = 7'h71;
        endcase
        return p;
    endfunction

    assign op_a = vec[AW-1:0];
    assign op_b = vec[VW-1:AW];
    assign prod = PW'(op_a) * PW'(op_b);
    assign sum  = SW'(op_a) + SW'(op_b);

    always_comb begin
        drive = vec;
        gold  = '0;
        mask  = '0;
        unique case (mode)
            MODE_MUL: begin
                gold = OW'(prod);
                mask = OW'((1 << PW) - 1);
            end
            MODE_ADD: begin
                gold = OW'(sum);
                mask = OW'((1 << SW) - 1);
            end
            default: begin
                drive = VW'(vec[HEX_W-1:0]);
                gold  = OW'(seg_pattern(vec[HEX_W-1:0]));
                mask  = OW'((1 << SEG_N) - 1);
            end
        endcase
    end

endmodule

// File: rtl/fit_ctrl.sv
module fit_ctrl
    import fit_pkg::*;
#(
    parameter int SW = SETTLE_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    sel,
    input  logic [SW-1:0] settle,
    output state_e        state,
    output mode_e         mode,
    output logic [VW-1:0] vec,
    output logic          accept,
    output logic          sample,
    output logic          done
);

    state_e        state_q, state_d;
    mode_e         mode_q;
    logic [VW-1:0] vec_q;
    logic [SW-1:0] wait_q;
    logic [SW-1:0] hold_q;
    logic          at_last;

    assign at_last = (vec_q == VW'(last_vec(mode_q)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETTLE;
            ST_SETTLE: if (wait_q == '0) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = at_last ? ST_FINISH : ST_SETTLE;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = (state_q == ST_IDLE) && start;
        sample = (state_q == ST_SAMPLE);
        done   = (state_q == ST_FINISH);
    end

    // sweep counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_MUL;
            vec_q  <= '0;
            wait_q <= '0;
            hold_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    mode_q <= decode_sel(sel);
                    vec_q  <= '0;
                    wait_q <= settle;
                    hold_q <= settle;
                end
                ST_SETTLE: if (wait_q != '0) wait_q <= wait_q - 1'b1;
                ST_SAMPLE: if (!at_last) begin
                    vec_q  <= vec_q + 1'b1;
                    wait_q <= hold_q;
                end
                ST_FINISH: ;
            endcase
        end
    end

    assign state = state_q;
    assign mode  = mode_q;
    assign vec   = vec_q;

endmodule

// File: rtl/fit_score.sv
module fit_score #(
    parameter int OW  = fit_pkg::OUT_W,
    parameter int SCW = fit_pkg::SCORE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           sample,
    input  logic           done,
    input  logic [OW-1:0]  gold,
    input  logic [OW-1:0]  mask,
    input  logic [OW-1:0]  observed,
    input  logic [SCW-1:0] max_pts,
    output logic [SCW-1:0] fitness,
    output logic           perfect
);

    localparam int CW = $clog2(OW + 1);

    logic [OW-1:0]  hit;
    logic [CW-1:0]  hit_cnt;
    logic [SCW-1:0] score_q;
    logic           have_q;

    for (genvar i = 0; i < OW; i++) begin : g_bit
        assign hit[i] = mask[i] & ~(observed[i] ^ gold[i]);
    end

    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < OW; i++) hit_cnt = hit_cnt + CW'(hit[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_q <= '0;
            have_q  <= 1'b0;
        end else begin
            if (clear)       score_q <= '0;
            else if (sample) score_q <= score_q + SCW'(hit_cnt);
            if (clear)       have_q  <= 1'b0;
            else if (done)   have_q  <= 1'b1;
        end
    end

    assign fitness = score_q;
    assign perfect = (done || have_q) && (score_q == max_pts);

endmodule

// File: rtl/fitness_scorer.sv
module fitness_scorer
    import fit_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          func_sel,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [OUT_W-1:0]    cut_out,
    output logic [VEC_W-1:0]    cut_in,
    output logic [SCORE_W-1:0]  fitness,
    output logic                done,
    output logic                perfect
);

    state_e             st_w;
    mode_e              mode_w;
    logic [VEC_W-1:0]   vec_w;
    logic               accept_w;
    logic               sample_w;
    logic [OUT_W-1:0]   gold_w;
    logic [OUT_W-1:0]   mask_w;
    logic [SCORE_W-1:0] max_w;

    fit_ctrl #(.SW(SETTLE_W), .VW(VEC_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .sel    (func_sel),
        .settle (settle_cycles),
        .state  (st_w),
        .mode   (mode_w),
        .vec    (vec_w),
        .accept (accept_w),
        .sample (sample_w),
        .done   (done)
    );

    fit_golden #(.OW(OUT_W), .VW(VEC_W), .AW(OPW)) u_golden (
        .mode  (mode_w),
        .vec   (vec_w),
        .drive (cut_in),
        .gold  (gold_w),
        .mask  (mask_w)
    );

    assign max_w = max_score(mode_w);

    fit_score #(.OW(OUT_W), .SCW(SCORE_W)) u_score (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept_w),
        .sample   (sample_w),
        .done     (done),
        .gold     (gold_w),
        .mask     (mask_w),
        .observed (cut_out),
        .max_pts  (max_w),
        .fitness  (fitness),
        .perfect  (perfect)
    );

endmodule

// File: rtl/fit_checker.sv
module fit_checker
    import fit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               done,
    input logic               perfect,
    input logic [SCORE_W-1:0] fitness,
    input logic [VEC_W-1:0]   drive,
    input state_e             state,
    input mode_e              mode
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_PERFECT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        perfect |-> (fitness == max_score(mode))); // R9

    AST_SCORE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        fitness <= max_score(mode)); // R6

    AST_SCORE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (fitness >= $past(fitness))); // R6

    AST_HOLD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> $stable(drive)); // R7

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(mode)); // R2

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (fitness == '0)); // R2

endmodule

bind fitness_scorer fit_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .perfect (perfect),
    .fitness (fitness),
    .drive   (cut_in),
    .state   (st_w),
    .mode    (mode_w)
);

// File: tb/fitness_scorer_test.sv
module fitness_scorer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] func_sel = 2'd0;
    logic [3:0] settle_cycles = 4'd0;
    logic [6:0] cut_out;
    logic [5:0] cut_in;
    logic [8:0] fitness;
    logic       done;
    logic       perfect;

    int checks = 0;
    int fails  = 0;

    // model circuit configuration
    logic [1:0] m_sel  = 2'd0;
    logic [2:0] f_kind = 3'd0;
    logic [2:0] f_bit  = 3'd0;

    always #5 clk = ~clk;

    fitness_scorer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .func_sel      (func_sel),
        .settle_cycles (settle_cycles),
        .cut_out       (cut_out),
        .cut_in        (cut_in),
        .fitness       (fitness),
        .done          (done),
        .perfect       (perfect)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] v);
        logic [6:0] p;
        case (v)
            4'h0: p = 7'h3F; 4'h1: p = 7'h06; 4'h2: p = 7'h5B; 4'h3: p = 7'h4F;
            4'h4: p = 7'h66; 4'h5: p = 7'h6D; 4'h6: p = 7'h7D; 4'h7: p = 7'h07;
            4'h8: p = 7'h7F; 4'h9: p = 7'h6F; 4'hA: p = 7'h77; 4'hB: p = 7'h7C;
            4'hC: p = 7'h39; 4'hD: p = 7'h5E; 4'hE: p = 7'h79; default: p = 7'h71;
        endcase
        return p;
    endfunction

    function automatic logic [6:0] model(input logic [1:0] s, input logic [5:0] x,
                                         input logic [2:0] k, input logic [2:0] b);
        logic [6:0] o;
        case (s)
            2'd0:    o = {1'b0, 6'({3'b0, x[2:0]} * {3'b0, x[5:3]})};
            2'd1:    o = {3'b0, {1'b0, x[2:0]} + {1'b0, x[5:3]}};
            default: o = ref_seg(x[3:0]);
        endcase
        case (k)
            3'd1: o[b] = 1'b0;
            3'd2: o[b] = 1'b1;
            3'd3: o[b] = ~o[b];
            3'd4: o = ~o;
            default: ;
        endcase
        return o;
    endfunction

    assign cut_out = model(m_sel, cut_in, f_kind, f_bit);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // entry: sel[20:19] settle[18:15] kind[14:12] bit[11:9] expected[8:0]
    // kinds: 0 none, 1 stuck low, 2 stuck high, 3 invert one bit, 4 invert all
    localparam logic [20:0] TBL [12] = '{
        {2'd0, 4'd0, 3'd0, 3'd0, 9'd384},  // product, clean
        {2'd0, 4'd1, 3'd1, 3'd0, 9'd368},  // product bit0 low: 16 misses
        {2'd0, 4'd0, 3'd3, 3'd6, 9'd384},  // unchecked bit 6 flipped
        {2'd0, 4'd0, 3'd2, 3'd5, 9'd326},  // product bit5 high: 58 misses
        {2'd1, 4'd2, 3'd0, 3'd0, 9'd256},  // sum, clean
        {2'd1, 4'd0, 3'd3, 3'd3, 9'd192},  // carry inverted everywhere
        {2'd1, 4'd1, 3'd4, 3'd0, 9'd0},    // everything inverted
        {2'd1, 4'd0, 3'd1, 3'd0, 9'd224},  // sum bit0 low: 32 misses
        {2'd2, 4'd0, 3'd0, 3'd0, 9'd112},  // segments, clean
        {2'd2, 4'd3, 3'd2, 3'd6, 9'd108},  // segment g high: 0,1,7,C miss
        {2'd2, 4'd0, 3'd4, 3'd0, 9'd0},    // segments inverted
        {2'd3, 4'd0, 3'd0, 3'd0, 9'd112}   // select 11 is segments too
    };

    task automatic run_sweep(input logic [20:0] e, input bit poke_busy);
        logic [1:0] s;
        int settle, n, mx, exp, cyc;
        string req;
        s      = e[20:19];
        settle = int'(e[18:15]);
        exp    = int'(e[8:0]);
        n      = (s < 2'd2) ? 64 : 16;
        mx     = (s == 2'd0) ? 384 : (s == 2'd1) ? 256 : 112;
        req    = (s == 2'd0) ? "R3 R6" : (s == 2'd1) ? "R4 R6" : "R5 R6";
        @(negedge clk);
        m_sel = s; f_kind = e[14:12]; f_bit = e[11:9];
        func_sel = s; settle_cycles = e[18:15]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(fitness == 9'd0, "R2", "fitness cleared on start", fitness, 0);
        check(perfect == 1'b0, "R9", "perfect cleared on start", perfect, 0);
        cyc = 1;
        @(posedge clk); #1;
        while (!done && cyc < 5000) begin
            if (poke_busy && cyc == 20) begin start = 1'b1; func_sel = 2'd2; end
            if (poke_busy && cyc == 21) start = 1'b0;
            @(posedge clk); #1;
            cyc++;
        end
        check(cyc == n * (settle + 2), "R7", "cycles to done", cyc, n * (settle + 2));
        check(fitness == 9'(exp), req, "score", fitness, exp);
        check(perfect == (exp == mx), "R9", "perfect at done", perfect, int'(exp == mx));
        @(posedge clk); #1;
        check(done == 1'b0, "R8", "done lasts one cycle", done, 0);
        repeat (3) @(posedge clk);
        #1;
        check(fitness == 9'(exp), "R8", "score held after done", fitness, exp);
        check(perfect == (exp == mx), "R9", "perfect held", perfect, int'(exp == mx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(fitness == 9'd0, "R1", "reset fitness", fitness, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);
        check(perfect == 1'b0, "R1", "reset perfect", perfect, 0);
        check(cut_in == 6'd0, "R1", "reset drive", cut_in, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) run_sweep(TBL[i], 1'b0);

        // R2: a start during a product sweep must not switch to segments or restart
        run_sweep({2'd0, 4'd1, 3'd0, 3'd0, 9'd384}, 1'b1);

        // R5: spot checks of the drive vector in segment mode, settle 0
        @(negedge clk);
        m_sel = 2'd2; f_kind = 3'd0; func_sel = 2'd2; settle_cycles = 4'd0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(cut_in == 6'd0, "R5", "first segment vector", cut_in, 0);
        repeat (26) @(posedge clk);
        #1;
        check(cut_in == 6'd13, "R5", "segment vector after 13 steps", cut_in, 13);
        repeat (10) @(posedge clk);
        #1;
        check(cut_in[5:4] == 2'd0, "R5", "upper drive bits", cut_in[5:4], 0);
        repeat (20) @(posedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule